// File: doc/BRIEF.md
# Register Bank with Pointer-Indirect Scratch RAM

This block pairs an 8-bit register bank with a small byte-wide scratch memory. The bank has eight general-purpose registers, two combinational read ports and one write port. One register, chosen by a parameter and by default the last one, is also the memory pointer. The scratch memory has one read path and one write path. Each path takes a short direct address field from the instruction, so a load and a store can both finish in the same cycle with no stall.

Direct address 0 has no storage cell of its own. When a direct field is zero, the access goes to the location held in the pointer register. This gives indirect addressing with no extra opcodes. Direct addresses 1 to 31 reach base cells 1 to 31. The pointer is a full 8 bits wide. It reaches the base cells, physical cell 0, and an extended region placed above the base cells. The extended region has 32 cells by default. Pointer values beyond the last physical cell address nothing.

Top module: `regram_core`

## Requirements
- R1: Synchronous active-high reset clears every register to 0, and both read ports then return 0 for any register index. The scratch memory is not cleared.
- R2: A register write with `rf_we` high lands on the next rising clock edge. A read of that register in the write cycle returns the previous value. This also holds for register 0 and for the pointer register (index 7).
- R3: The two register read ports are independent. Any pair of indices, including the same index on both ports, returns the contents of each selected register.
- R4: A direct address field in the range 1 to 31 reads or writes scratch cell number equal to the field value.
- R5: A read with direct address field 0 returns the cell whose number is the current value of register 7.
- R6: A write with direct address field 0 stores into the cell whose number is the current value of register 7.
- R7: A memory read and a memory write in the same cycle both complete. If they target different cells, the read returns that cell's contents. If they target the same cell, the read returns the content from before the write, and the new byte is visible from the next cycle.
- R8: Pointer values 32 to 63 reach extended cells that are distinct from the base cells. Writing cell 32+k leaves base cell k unchanged.
- R9: For pointer values of 64 and above, an indirect write changes no cell and an indirect read returns 0x00.
- R10: When register 7 is written in the same cycle as an indirect memory access, that access uses the old pointer value.
- R11: With `rf_we` low no register changes, and with `mem_we` low no memory cell changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register bank |
| rf_we | input | 1 | Register write enable |
| rf_wsel | input | 3 | Register index to write |
| rf_wdata | input | 8 | Register write data |
| rf_rsel_a | input | 3 | Register index for read port A |
| rf_rdata_a | output | 8 | Read port A data (combinational) |
| rf_rsel_b | input | 3 | Register index for read port B |
| rf_rdata_b | output | 8 | Read port B data (combinational) |
| mem_we | input | 1 | Scratch memory write enable |
| mem_waddr | input | 5 | Direct write address; 0 selects the pointer |
| mem_wdata | input | 8 | Scratch memory write data |
| mem_raddr | input | 5 | Direct read address; 0 selects the pointer |
| mem_rdata | output | 8 | Scratch memory read data (combinational) |

## Verification
The bench builds the block with its defaults: eight registers, the pointer in register 7, 32 base cells and 32 extended cells. With these values the bench can sweep every register pair, every direct address and every in-range pointer value, all 64 physical cells, in a few hundred cycles. Pointer values 64, 128 and 255 exercise the region beyond the last physical cell. Each cycle is compared with an arithmetic model kept in the bench. The model applies register writes after it resolves the pointer, so same-cycle pointer updates are covered as well.

// File: rtl/regram_pkg.sv
`timescale 1ns/1ps
package regram_pkg;

    // Architectural byte width; the pointer is exactly one data word wide.
    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    // Resolved physical location of one memory access.
    typedef struct packed {
        byte_t loc;       // physical cell number
        logic  in_range;  // cell exists in the array
    } ram_loc_t;

    // Direct field value 0 is the indirect escape.
    function automatic byte_t pick_location(input byte_t direct_ext, input byte_t ptr);
        return (direct_ext == '0) ? ptr : direct_ext;
    endfunction

    function automatic logic loc_exists(input byte_t loc, input int depth);
        return int'(loc) < depth;
    endfunction

endpackage

// File: rtl/rr_regbank.sv
`timescale 1ns/1ps
module rr_regbank
    import regram_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int PTR_REG  = 7,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  byte_t            wdata,
    input  logic [SEL_W-1:0] rsel_a,
    input  logic [SEL_W-1:0] rsel_b,
    output byte_t            rdata_a,
    output byte_t            rdata_b,
    output byte_t            ptr_val
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            regs[wsel] <= wdata;
        end
    end

    // Reads see the flop outputs, so a same-cycle write is not forwarded.
    always_comb begin
        rdata_a = regs[rsel_a];
        rdata_b = regs[rsel_b];
        ptr_val = regs[PTR_REG];
    end

    AST_REG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(wsel)] == $past(wdata)); // R2

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs)); // R11

endmodule

// File: rtl/rr_addr_xlate.sv
`timescale 1ns/1ps
module rr_addr_xlate
    import regram_pkg::*;
#(
    parameter int DIR_W = 5,
    parameter int DEPTH = 64
) (
    input  logic [DIR_W-1:0] direct,
    input  byte_t            ptr,
    output ram_loc_t         loc
);

    byte_t direct_ext;

    always_comb begin
        direct_ext   = byte_t'(direct);
        loc.loc      = pick_location(direct_ext, ptr);
        loc.in_range = loc_exists(loc.loc, DEPTH);
    end

endmodule

// File: rtl/rr_scratch_ram.sv
`timescale 1ns/1ps
module rr_scratch_ram
    import regram_pkg::*;
#(
    parameter int DEPTH    = 64,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  ram_loc_t wloc,
    input  byte_t    wdata,
    input  ram_loc_t rloc,
    output byte_t    rdata
);

    logic [DEPTH-1:0][DATA_W-1:0] mem;
    logic [IDX_W-1:0]             widx;
    logic [IDX_W-1:0]             ridx;
    logic                         wr_go;

    always_comb begin
        widx  = wloc.loc[IDX_W-1:0];
        ridx  = rloc.loc[IDX_W-1:0];
        wr_go = we && wloc.in_range;
    end

    // No reset on storage: contents survive reset.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[widx] <= wdata;
        end
    end

    // Combinational read of the old content; the write lands at the edge.
    always_comb begin
        rdata = rloc.in_range ? mem[ridx] : '0;
    end

    AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && wloc.in_range) |=> mem[$past(widx)] == $past(wdata)); // R6

    AST_RAM_OOR_DROP: assert property (@(posedge clk) disable iff (rst)
        (we && !wloc.in_range) |=> $stable(mem)); // R9

    AST_RAM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem)); // R11

endmodule

// File: rtl/regram_core.sv
`timescale 1ns/1ps
module regram_core
    import regram_pkg::*;
#(
    parameter int NUM_REGS   = 8,
    parameter int PTR_REG    = 7,
    parameter int BASE_DEPTH = 32,
    parameter int EXT_DEPTH  = 32,
    localparam int SEL_W     = $clog2(NUM_REGS),
    localparam int DIR_W     = $clog2(BASE_DEPTH),
    localparam int RAM_DEPTH = BASE_DEPTH + EXT_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rf_we,
    input  logic [SEL_W-1:0] rf_wsel,
    input  logic [7:0]       rf_wdata,
    input  logic [SEL_W-1:0] rf_rsel_a,
    output logic [7:0]       rf_rdata_a,
    input  logic [SEL_W-1:0] rf_rsel_b,
    output logic [7:0]       rf_rdata_b,
    input  logic             mem_we,
    input  logic [DIR_W-1:0] mem_waddr,
    input  logic [7:0]       mem_wdata,
    input  logic [DIR_W-1:0] mem_raddr,
    output logic [7:0]       mem_rdata
);

    byte_t    ptr_val;
    ram_loc_t loc_q [2];   // [0] read path, [1] write path
    logic [DIR_W-1:0] dir_q [2];

    always_comb begin
        dir_q[0] = mem_raddr;
        dir_q[1] = mem_waddr;
    end

    rr_regbank #(
        .NUM_REGS (NUM_REGS),
        .PTR_REG  (PTR_REG)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .wsel    (rf_wsel),
        .wdata   (rf_wdata),
        .rsel_a  (rf_rsel_a),
        .rsel_b  (rf_rsel_b),
        .rdata_a (rf_rdata_a),
        .rdata_b (rf_rdata_b),
        .ptr_val (ptr_val)
    );

    for (genvar g = 0; g < 2; g++) begin : g_xlate
        rr_addr_xlate #(
            .DIR_W (DIR_W),
            .DEPTH (RAM_DEPTH)
        ) u_xlate (
            .direct (dir_q[g]),
            .ptr    (ptr_val),
            .loc    (loc_q[g])
        );
    end

    rr_scratch_ram #(
        .DEPTH (RAM_DEPTH)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .wloc  (loc_q[1]),
        .wdata (mem_wdata),
        .rloc  (loc_q[0]),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/regram_core_bench.sv
`timescale 1ns/1ps
module regram_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rf_we = 1'b0;
    logic [2:0] rf_wsel = '0;
    logic [7:0] rf_wdata = '0;
    logic [2:0] rf_rsel_a = '0;
    logic [2:0] rf_rsel_b = '0;
    logic [7:0] rf_rdata_a;
    logic [7:0] rf_rdata_b;
    logic       mem_we = 1'b0;
    logic [4:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;
    logic [4:0] mem_raddr = '0;
    logic [7:0] mem_rdata;

    always #10 clk = ~clk;

    regram_core u_regram_core (
        .clk        (clk),
        .rst        (rst),
        .rf_we      (rf_we),
        .rf_wsel    (rf_wsel),
        .rf_wdata   (rf_wdata),
        .rf_rsel_a  (rf_rsel_a),
        .rf_rdata_a (rf_rdata_a),
        .rf_rsel_b  (rf_rsel_b),
        .rf_rdata_b (rf_rdata_b),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .mem_raddr  (mem_raddr),
        .mem_rdata  (mem_rdata)
    );

    int         n_run  = 0;
    int         n_fail = 0;
    logic [7:0] m_reg [8];
    logic [7:0] m_mem [64];
    bit         m_known [64];

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    function automatic int phys(input logic [4:0] d);
        return (d == 5'd0) ? int'(m_reg[7]) : int'(d);
    endfunction

    // One cycle: drive after the falling edge, check before the rising edge,
    // then advance the model the way the requirements say.
    task automatic cyc(input string tag,
                       input bit rfwe, input int ws, input logic [7:0] wd,
                       input bit mwe, input logic [4:0] wa, input logic [7:0] mwd,
                       input logic [4:0] ra, input int sa, input int sb);
        int rp;
        int wp;
        rf_we     = rfwe;
        rf_wsel   = 3'(ws);
        rf_wdata  = wd;
        mem_we    = mwe;
        mem_waddr = wa;
        mem_wdata = mwd;
        mem_raddr = ra;
        rf_rsel_a = 3'(sa);
        rf_rsel_b = 3'(sb);
        #2;
        chk(tag, "read port A", rf_rdata_a, m_reg[sa]);
        chk(tag, "read port B", rf_rdata_b, m_reg[sb]);
        rp = phys(ra);
        if (rp >= 64) chk(tag, "ram read", mem_rdata, 8'h00);
        else if (m_known[rp]) chk(tag, "ram read", mem_rdata, m_mem[rp]);
        wp = phys(wa);
        if (mwe && wp < 64) begin
            m_mem[wp]   = mwd;
            m_known[wp] = 1'b1;
        end
        if (rfwe) m_reg[ws] = wd;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        for (int i = 0; i < 64; i++) m_known[i] = 1'b0;
        // drive garbage writes during reset: must not survive R1
        rf_we = 1'b1; rf_wsel = 3'd3; rf_wdata = 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all registers read 0 after reset
        for (int i = 0; i < 8; i++) cyc("R1", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd1, i, 7 - i);

        // R2: write each register; same-cycle read sees the old value
        for (int i = 0; i < 8; i++)
            cyc("R2", 1, i, 8'((i * 37 + 5) & 255), 0, 5'd1, 8'h00, 5'd1, i, i);
        for (int i = 0; i < 8; i++)
            cyc("R2", 1, i, 8'((i * 91 + 17) & 255), 0, 5'd1, 8'h00, 5'd1, i, (i + 1) % 8);

        // R3: every pair of read indices
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                cyc("R3", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd1, a, b);

        // R11: rf_we low, other write inputs busy
        for (int i = 0; i < 8; i++) cyc("R11", 0, i, 8'h5A ^ 8'(i), 0, 5'd1, 8'h00, 5'd1, i, 7);

        // R4 / R7: direct writes 1..31 while reading the previous cell
        for (int a = 1; a < 32; a++)
            cyc("R4", 0, 0, 8'h00, 1, 5'(a), 8'((a * 7 + 3) & 255), 5'(a > 1 ? a - 1 : 1), 0, 1);
        for (int a = 1; a < 32; a++) cyc("R4", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'(a), 0, 1);

        // R5 / R6 / R7 / R8: pointer sweep over all 64 physical cells
        for (int k = 0; k < 64; k++) begin
            cyc("R6", 1, 7, 8'(k), 0, 5'd1, 8'h00, 5'd2, 7, 0);
            cyc("R7", 0, 0, 8'h00, 1, 5'd0, 8'(k ^ 8'hA5), 5'd0, 7, 0);
            cyc("R5", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd0, 7, 0);
        end
        // base cells must still hold what the pointer sweep wrote, not the ext data
        for (int a = 1; a < 32; a++) cyc("R8", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'(a), 0, 7);
        // rewrite extended cells and confirm base counterparts unchanged
        for (int k = 32; k < 64; k++) begin
            cyc("R8", 1, 7, 8'(k), 0, 5'd1, 8'h00, 5'd1, 7, 7);
            cyc("R8", 0, 0, 8'h00, 1, 5'd0, 8'(k * 3), 5'(k - 32 == 0 ? 1 : k - 32), 7, 0);
            cyc("R8", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd0, 7, 0);
        end

        // R9: pointer beyond the array
        for (int j = 0; j < 3; j++) begin
            cyc("R9", 1, 7, (j == 0) ? 8'd64 : (j == 1) ? 8'd128 : 8'd255,
                0, 5'd1, 8'h00, 5'd1, 7, 7);
            cyc("R9", 0, 0, 8'h00, 1, 5'd0, 8'hC3, 5'd0, 7, 0);
            cyc("R9", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd0, 7, 0);
        end
        for (int k = 0; k < 64; k++) begin
            cyc("R9", 1, 7, 8'(k), 0, 5'd1, 8'h00, 5'd1, 7, 7);
            cyc("R9", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd0, 7, 0);
        end

        // R10: pointer rewritten in the same cycle as an indirect write/read
        cyc("R10", 1, 7, 8'd10, 0, 5'd1, 8'h00, 5'd1, 7, 7);
        cyc("R10", 1, 7, 8'd20, 1, 5'd0, 8'h3C, 5'd0, 7, 0);
        cyc("R10", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd10, 7, 0);
        cyc("R10", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd20, 7, 0);
        cyc("R10", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd0, 7, 0);

        // R7: same-cell read/write in one cycle
        cyc("R7", 0, 0, 8'h00, 1, 5'd5, 8'h99, 5'd5, 0, 1);
        cyc("R7", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'd5, 0, 1);

        // R11: mem_we low, address and data toggling
        for (int a = 0; a < 32; a++) cyc("R11", 0, 0, 8'h00, 0, 5'(a), 8'hFF, 5'(a), 0, 7);
        for (int a = 0; a < 32; a++) cyc("R11", 0, 0, 8'h00, 0, 5'd1, 8'h00, 5'(a), 0, 7);

        summary();
        $finish;
    end

endmodule